// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a reprogrammable AND plane that feeds a fixed OR plane. Sixteen logic signals enter it: eight dedicated inputs and eight feedback signals. Each signal is presented to the array twice, once true and once inverted, which gives 32 array columns. Each of the 64 product-term rows forms the AND of the columns that its fuse word connects. The rows are split into eight groups of eight, and each group drives one sum output through a fixed OR.

Fuse words are written one row per clock through a plain address/data/strobe port, and they are held in flip-flops. A row takes part in its group's sum only after it has been written at least once since reset. For each group, a mode bit can take the group's last row out of the OR and present it as a separate enable term instead. The block's outputs are the sums, the enables and the raw value of every product term. Output muxing, polarity, registering and tristate belong to the surrounding logic.

Top module: `pal_sop_array`

## Requirements
- R1: Column 2k carries signal k true and column 2k+1 carries it inverted. Signals 0..7 are in_i[0..7] and signals 8..15 are fb_i[0..7]. A fuse bit of 1 connects that column to the row.
- R2: A product term is the AND of its connected columns. A row with no fuse bit set evaluates to 1.
- R3: A row that connects both the true and the inverted column of the same signal evaluates to 0, whatever the inputs.
- R4: When wr_en_i is high at a rising clk_i edge, row wr_addr_i is replaced by wr_data_i. The new row applies from that edge on, and all other rows keep their contents.
- R5: While rst_ni is low, and after it until the first write, every row is blank and unused: term_o is all ones and sum_o is all zeros.
- R6: Row r belongs to group r/8. sum_o[g] is the OR of the used rows 8g..8g+7 (subject to R8). It is 0 when no used row of the group is 1.
- R7: A row that has not been written since reset never contributes to sum_o, even though its term_o bit reads 1.
- R8: When io_mode_i[g] is 1, row 8g+7 is left out of sum_o[g], and en_o[g] equals that row's term value, written or not.
- R9: When io_mode_i[g] is 0, en_o[g] is 1 and row 8g+7 is part of sum_o[g] like the other rows.
- R10: term_o[r] presents the current value of product term r for all 64 rows. term_o, sum_o and en_o follow in_i, fb_i and io_mode_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for fuse writes |
| rst_ni | input | 1 | Active-low asynchronous reset; blanks every row |
| wr_en_i | input | 1 | Fuse row write strobe |
| wr_addr_i | input | 6 | Row to write |
| wr_data_i | input | 32 | Fuse word, one bit per column |
| in_i | input | 8 | Dedicated array inputs |
| fb_i | input | 8 | Feedback array inputs |
| io_mode_i | input | 8 | Per group: last row drives the enable instead of the sum |
| term_o | output | 64 | Value of every product term |
| sum_o | output | 8 | Sum of products per group |
| en_o | output | 8 | Enable term per group |

## Verification
A fuse write has no effect until the rising edge that captures it. From that edge on, and for the rest of the clock, all three outputs are combinational functions of the stored fuses and the present inputs. The bench changes stimulus just after a falling edge. It compares term_o, sum_o and en_o with its behavioural model at the next falling edge, half a period after any write edge. That instant is after the write has landed and after the inputs have settled. The model applies the write at the same rising edge and evaluates the terms from the requirement rules, not from the RTL's structure.

// File: rtl/pal_sop_pkg.sv
package pal_sop_pkg;
  parameter int unsigned NUM_IN    = 8;
  parameter int unsigned NUM_FB    = 8;
  parameter int unsigned NUM_GRP   = 8;
  parameter int unsigned GRP_TERMS = 8;

  localparam int unsigned NUM_SIG = NUM_IN + NUM_FB;
  localparam int unsigned NUM_COL = 2 * NUM_SIG;
  localparam int unsigned NUM_ROW = NUM_GRP * GRP_TERMS;
  localparam int unsigned ADDR_W  = $clog2(NUM_ROW);

  typedef logic [NUM_COL-1:0] fuse_row_t;
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
  parameter int unsigned NROW = 64,
  parameter int unsigned NCOL = 32,
  parameter int unsigned AW   = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [NCOL-1:0]           wr_data_i,
  output logic [NROW-1:0][NCOL-1:0] fuse_o,
  output logic [NROW-1:0]           used_o
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fuse_o[r] <= '0;
        used_o[r] <= 1'b0;
      end else if (hit) begin
        fuse_o[r] <= wr_data_i;
        used_o[r] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int unsigned NIN  = 8,
  parameter int unsigned NFB  = 8,
  parameter int unsigned NROW = 64,
  localparam int unsigned NSIG = NIN + NFB,
  localparam int unsigned NCOL = 2 * NSIG
) (
  input  logic [NIN-1:0]            in_i,
  input  logic [NFB-1:0]            fb_i,
  input  logic [NROW-1:0][NCOL-1:0] fuse_i,
  output logic [NROW-1:0]           term_o
);
  logic [NSIG-1:0] sig;
  logic [NCOL-1:0] col;

  assign sig = {fb_i, in_i};

  for (genvar s = 0; s < NSIG; s++) begin : g_col
    assign col[2*s]   = sig[s];
    assign col[2*s+1] = ~sig[s];
  end

  // Unconnected columns are forced high; blank rows AND to 1, clashing pairs to 0.
  for (genvar r = 0; r < NROW; r++) begin : g_term
    assign term_o[r] = &(col | ~fuse_i[r]);
  end
endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
  parameter int unsigned NGRP  = 8,
  parameter int unsigned TERMS = 8,
  localparam int unsigned NROW = NGRP * TERMS
) (
  input  logic [NROW-1:0] term_i,
  input  logic [NROW-1:0] used_i,
  input  logic [NGRP-1:0] io_mode_i,
  output logic [NGRP-1:0] sum_o,
  output logic [NGRP-1:0] en_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned BASE = g * TERMS;
    logic [TERMS-1:0] live;
    logic             head_any;
    logic             tail;
    assign live     = term_i[BASE +: TERMS] & used_i[BASE +: TERMS];
    assign head_any = |live[TERMS-2:0];
    assign tail     = live[TERMS-1] & ~io_mode_i[g];
    assign sum_o[g] = head_any | tail;
    assign en_o[g]  = io_mode_i[g] ? term_i[BASE+TERMS-1] : 1'b1;
  end
endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
  import pal_sop_pkg::*;
#(
  parameter int unsigned N_IN  = NUM_IN,
  parameter int unsigned N_FB  = NUM_FB,
  parameter int unsigned N_GRP = NUM_GRP,
  parameter int unsigned N_TRM = GRP_TERMS,
  localparam int unsigned N_COL = 2 * (N_IN + N_FB),
  localparam int unsigned N_ROW = N_GRP * N_TRM,
  localparam int unsigned AW    = $clog2(N_ROW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [N_COL-1:0] wr_data_i,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_FB-1:0]  fb_i,
  input  logic [N_GRP-1:0] io_mode_i,
  output logic [N_ROW-1:0] term_o,
  output logic [N_GRP-1:0] sum_o,
  output logic [N_GRP-1:0] en_o
);
  logic [N_ROW-1:0][N_COL-1:0] fuse;
  logic [N_ROW-1:0]            used;

  pal_fuse_store #(.NROW(N_ROW), .NCOL(N_COL), .AW(AW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .fuse_o   (fuse),
    .used_o   (used)
  );

  pal_and_plane #(.NIN(N_IN), .NFB(N_FB), .NROW(N_ROW)) u_and (
    .in_i  (in_i),
    .fb_i  (fb_i),
    .fuse_i(fuse),
    .term_o(term_o)
  );

  pal_or_plane #(.NGRP(N_GRP), .TERMS(N_TRM)) u_or (
    .term_i   (term_o),
    .used_i   (used),
    .io_mode_i(io_mode_i),
    .sum_o    (sum_o),
    .en_o     (en_o)
  );
endmodule

// File: rtl/pal_sop_array_chk.sv
module pal_sop_array_chk #(
  parameter int unsigned N_GRP = 8,
  parameter int unsigned N_TRM = 8,
  parameter int unsigned N_COL = 32,
  parameter int unsigned AW    = 6,
  localparam int unsigned N_ROW = N_GRP * N_TRM
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [N_COL-1:0] wr_data_i,
  input logic [N_GRP-1:0] io_mode_i,
  input logic [N_ROW-1:0] term_o,
  input logic [N_GRP-1:0] sum_o,
  input logic [N_GRP-1:0] en_o
);
  p_en_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o | io_mode_i) == {N_GRP{1'b1}});

  p_blank_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == '0) |=> term_o[$past(wr_addr_i)]);

  p_clash_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1:0] == 2'b11) |=> !term_o[$past(wr_addr_i)]);

  p_reset_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sum_o == '0 && term_o == {N_ROW{1'b1}}));

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    p_sum_needs_term_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o[g] |-> (|term_o[g*N_TRM +: N_TRM]));

    p_io_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      io_mode_i[g] |-> (en_o[g] == term_o[g*N_TRM + N_TRM - 1]));
  end
endmodule

bind pal_sop_array pal_sop_array_chk #(
  .N_GRP(N_GRP), .N_TRM(N_TRM), .N_COL(N_COL), .AW(AW)
) u_chk (.*);

// File: tb/tb_pal_sop_array.sv
module tb_pal_sop_array;
  localparam int NROW = 64;
  localparam int NGRP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  in_v = '0;
  logic [7:0]  fb_v = '0;
  logic [7:0]  io_mode = '0;
  logic [63:0] term;
  logic [7:0]  sum;
  logic [7:0]  en;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_fuse [NROW];
  bit          m_used [NROW];

  always #2 clk = ~clk;

  pal_sop_array dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .in_i(in_v), .fb_i(fb_v), .io_mode_i(io_mode),
    .term_o(term), .sum_o(sum), .en_o(en)
  );

  // Reference state, updated at the same edge as the design's fuses (R4, R5)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROW; r++) begin
        m_fuse[r] <= '0;
        m_used[r] <= 1'b0;
      end
    end else if (wr_en) begin
      m_fuse[wr_addr] <= wr_data;
      m_used[wr_addr] <= 1'b1;
    end
  end

  function automatic bit sig_val(int s);
    return (s < 8) ? in_v[s] : fb_v[s-8];
  endfunction

  function automatic bit row_val(int r);
    bit v = 1'b1;
    for (int s = 0; s < 16; s++) begin
      if (m_fuse[r][2*s] && !sig_val(s)) v = 1'b0;
      if (m_fuse[r][2*s+1] && sig_val(s)) v = 1'b0;
    end
    return v;
  endfunction

  task automatic check_all(string tag);
    logic [63:0] e_term;
    logic [7:0]  e_sum;
    logic [7:0]  e_en;
    for (int r = 0; r < NROW; r++) e_term[r] = row_val(r);
    for (int g = 0; g < NGRP; g++) begin
      e_sum[g] = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (k == 7 && io_mode[g]) continue;
        if (m_used[g*8+k] && e_term[g*8+k]) e_sum[g] = 1'b1;
      end
      e_en[g] = io_mode[g] ? e_term[g*8+7] : 1'b1;
    end
    n_chk += 3;
    if (term !== e_term) begin
      n_fail++;
      $display("FAIL %s term_o act %h exp %h", tag, term, e_term);
    end
    if (sum !== e_sum) begin
      n_fail++;
      $display("FAIL %s sum_o act %h exp %h", tag, sum, e_sum);
    end
    if (en !== e_en) begin
      n_fail++;
      $display("FAIL %s en_o act %h exp %h", tag, en, e_en);
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic write_row(int a, logic [31:0] d, string tag);
    wr_en = 1'b1;
    wr_addr = 6'(a);
    wr_data = d;
    tick(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R5 in reset");
    rst_n = 1'b1;
    in_v = 8'hA5;
    fb_v = 8'h3C;
    tick("R5 after reset");

    // R1 R2 R6: row 0 connects in_i[0] true
    write_row(0, 32'h0000_0001, "R1 R4 write true column");
    in_v = 8'h00; tick("R1 R2 R6 true col low");
    in_v = 8'h01; tick("R1 R2 R6 true col high");

    // R1: row 1 = in_i[1] inverted AND fb_i[0] true
    write_row(1, 32'h0001_0008, "R1 R4 write complement");
    in_v = 8'h00; fb_v = 8'h01; tick("R1 R2 complement and fb true");
    in_v = 8'h02; tick("R1 R2 complement blocked");

    // R3: row 2 connects both polarities of in_i[0]
    write_row(2, 32'h0000_0003, "R3 write clash");
    for (int v = 0; v < 4; v++) begin
      in_v = 8'(v);
      tick("R3 clash row");
    end

    // R2 R7: group 1 gets one blank written row, group 2 stays unused
    write_row(8, 32'h0, "R2 R7 blank row used");
    in_v = 8'hFF; fb_v = 8'hFF; tick("R7 unused group stays low");

    // R8 R9: last row of group 2
    io_mode = 8'h00;
    write_row(23, 32'h0, "R9 tail in sum");
    tick("R9 tail in sum");
    io_mode = 8'h04; tick("R8 tail moved to enable");
    write_row(23, 32'h0000_0010, "R8 enable from in2");
    in_v = 8'h00; tick("R8 enable low");
    in_v = 8'h04; tick("R8 enable high");
    io_mode = 8'hFF; tick("R8 unwritten tails enable");

    // R4 R10: random writes, inputs and modes
    for (int i = 0; i < 400; i++) begin
      in_v = 8'($urandom);
      fb_v = 8'($urandom);
      io_mode = 8'($urandom);
      if ($urandom_range(0, 2) != 0) begin
        logic [31:0] d;
        d = $urandom & $urandom;
        if ($urandom_range(0, 4) == 0) d = 32'h0;
        write_row($urandom_range(0, 63), d, "R4 R10 random write");
      end else begin
        tick("R4 R10 random hold");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule